// File: doc/BRIEF.md
# Dot-Matrix Scan and Attribute Renderer

This block drives four 5x7 LED character cells by row multiplexing. It holds no character storage of its own. On every row slot it presents the four 7-bit character codes and the current row index to an external character generator. It then takes back a 5-bit dot pattern per cell and decides how each cell must look for that row. A cell may show its glyph, show a cursor, or stay dark, and the decision depends on the per-cell flag, the attribute controls, global blink, lamp test and the blink phase input from a timebase.

The resolved patterns drive the 20 column enables while one row select is active. Intensity comes from duty-cycle gating: each row slot is split into four sub-slots, and a cell's columns are enabled only in the first N of them. A cursor replaces a glyph only at the output, so the character codes on the input side are never rewritten.

A two-state scan machine sequences the work. ST_FETCH is a dark cycle in which the generator is addressed and the cell decisions are latched; its transition "latch" always goes to ST_DRIVE with sub-slot 0. ST_DRIVE has two transitions. "step" advances the sub-slot while it is below 3. "row_done" returns to ST_FETCH after sub-slot 3 and advances the row index, wrapping from 6 back to 0. Reset enters ST_FETCH at row 0.

Top module: `dot_scan_renderer`

## Requirements
- R1: After reset the scan starts at row 0, and row slots repeat rows 0,1,...,6,0,... Each row slot is one dark fetch cycle (row_sel_o and col_en_o all zero) followed by four drive cycles, sub-slots 0 to 3. During a drive cycle row_sel_o has only bit `row` set. While rst_n is low both outputs are zero.
- R2: Brightness code bright_i selects how many sub-slots a glyph is lit in: 00 lights 0, 01 lights 1, 10 lights 2 and 11 lights 4. Lit sub-slots always start at sub-slot 0.
- R3: Cell i takes its code from chars_i[8i+6:8i] and its flag from chars_i[8i+7]. Its code appears on cg_code_o[7i+6:7i], and the row being fetched appears on cg_row_o. A cell showing its glyph drives col_en_o[5i+4:5i] with the pattern returned on cg_cols_i[5i+4:5i].
- R4: A cursor lights all five columns of its cell. It is lit in sub-slots 0 and 1 only, and never in more sub-slots than the brightness allows, so it shows in sub-slot 0 only at code 01.
- R5: Attributes affect a cell only when both its flag and attr_en_i are 1. Otherwise the cell shows its glyph.
- R6: With the attribute active, attr_mode_i selects the look. 00 gives a steady cursor. 01 gives the glyph when blink_phase_i=1 and dark otherwise. 10 gives a cursor when blink_phase_i=1 and dark otherwise. 11 gives the glyph when blink_phase_i=1 and a cursor when it is 0.
- R7: When blink_all_i=1 and blink_phase_i=0, every cell is dark whatever the flags are. When blink_phase_i=1, the global blink has no effect.
- R8: Lamp test lights all 20 columns in sub-slots 0 and 1 of every row. It overrides brightness 00, global blink and all attributes.
- R9: Brightness 00 darkens every cell, including cursors, unless lamp test is on.
- R10: All inputs are sampled once per row slot, at the end of its fetch cycle. A change during the drive cycles has no effect until the next row slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chars_i | input | 32 | Four cells, each with a flag in bit 7 and a code in bits 6:0 |
| bright_i | input | 2 | Brightness code |
| attr_en_i | input | 1 | Enables per-cell attributes |
| attr_mode_i | input | 2 | Attribute look selector |
| blink_all_i | input | 1 | Whole-display blink |
| lamp_test_i | input | 1 | Lights all dots at half duty |
| blink_phase_i | input | 1 | Blink phase from the timebase, 1 = on half |
| cg_row_o | output | 3 | Row index presented to the character generator |
| cg_code_o | output | 28 | Four 7-bit codes presented to the character generator |
| cg_cols_i | input | 20 | Dot pattern for the presented row, 5 bits per cell |
| row_sel_o | output | 7 | One-hot row drive |
| col_en_o | output | 20 | Column enables, 5 per cell, cell 0 in the low bits |

## Verification
The hardest behaviour to reach from the ports is the R10 sampling window. Inputs that change in the middle of a row slot must leave that slot's remaining sub-slots untouched. To reach it, the driver waits for a fetch cycle, pushes the expected values for the whole slot, and then switches lamp test on and brightness to 00 two drive cycles later. Every later sub-slot must still match the values pushed earlier. The blink-phase attribute looks are reached by holding the phase input at each level for one full row slot, with a flagged cell beside an unflagged one.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

    localparam int SUB_SLOTS = 4;
    localparam int SUB_W     = 2;
    localparam int CNT_W     = 3;

    typedef enum logic [0:0] {
        ST_FETCH = 1'b0,
        ST_DRIVE = 1'b1
    } scan_state_t;

    typedef enum logic [1:0] {
        LOOK_DARK   = 2'd0,
        LOOK_GLYPH  = 2'd1,
        LOOK_CURSOR = 2'd2,
        LOOK_LAMP   = 2'd3
    } look_t;

    localparam logic [1:0] MODE_CURSOR     = 2'b00;
    localparam logic [1:0] MODE_BLINK_CHAR = 2'b01;
    localparam logic [1:0] MODE_BLINK_CUR  = 2'b10;
    localparam logic [1:0] MODE_ALTERNATE  = 2'b11;

    // Number of lit sub-slots for a glyph at a brightness code.
    function automatic logic [CNT_W-1:0] glyph_slots(input logic [1:0] code);
        logic [CNT_W-1:0] n;
        unique case (code)
            2'b00:   n = 3'd0;
            2'b01:   n = 3'd1;
            2'b10:   n = 3'd2;
            default: n = 3'd4;
        endcase
        return n;
    endfunction

    // Cursor dots are capped at half duty.
    function automatic logic [CNT_W-1:0] cursor_slots(input logic [1:0] code);
        logic [CNT_W-1:0] n;
        n = glyph_slots(code);
        return (n > 3'd2) ? 3'd2 : n;
    endfunction

endpackage

// File: rtl/scan_seq.sv
module scan_seq
    import dsr_pkg::*;
#(
    parameter int ROWS  = 7,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    output scan_state_t      state_o,
    output logic [ROW_W-1:0] row_o,
    output logic [SUB_W-1:0] sub_o
);

    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);
    localparam logic [SUB_W-1:0] LAST_SUB = SUB_W'(SUB_SLOTS - 1);

    scan_state_t      state_q, state_d;
    logic [ROW_W-1:0] row_q, row_d;
    logic [SUB_W-1:0] sub_q, sub_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
            row_q   <= '0;
            sub_q   <= '0;
        end else begin
            state_q <= state_d;
            row_q   <= row_d;
            sub_q   <= sub_d;
        end
    end

    always_comb begin
        state_d = state_q;
        row_d   = row_q;
        sub_d   = sub_q;
        unique case (state_q)
            ST_FETCH: begin
                state_d = ST_DRIVE;
                sub_d   = '0;
            end
            ST_DRIVE: begin
                if (sub_q != LAST_SUB) begin
                    sub_d = sub_q + 1'b1;
                end else begin
                    state_d = ST_FETCH;
                    sub_d   = '0;
                    row_d   = (row_q == LAST_ROW) ? '0 : row_q + 1'b1;
                end
            end
            default: state_d = ST_FETCH;
        endcase
    end

    assign state_o = state_q;
    assign row_o   = row_q;
    assign sub_o   = sub_q;

    p_row_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        row_q <= LAST_ROW);
    p_fetch_to_drive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_FETCH |=> state_q == ST_DRIVE && sub_q == '0);
    p_drive_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRIVE && sub_q == LAST_SUB) |=> state_q == ST_FETCH);
    p_row_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_FETCH |=> $stable(row_q));

endmodule

// File: rtl/cell_lane.sv
module cell_lane
    import dsr_pkg::*;
#(
    parameter int COLS = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_i,
    input  logic             drive_i,
    input  logic [SUB_W-1:0] sub_i,
    input  logic             flag_i,
    input  logic [1:0]       bright_i,
    input  logic             attr_en_i,
    input  logic [1:0]       mode_i,
    input  logic             blink_all_i,
    input  logic             lamp_i,
    input  logic             phase_i,
    input  logic [COLS-1:0]  glyph_i,
    output logic [COLS-1:0]  cols_o
);

    look_t            look;
    logic [COLS-1:0]  pat_d, pat_q;
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             lit;

    // Decide the look of this cell for the row being fetched.
    always_comb begin
        look = LOOK_GLYPH;
        if (lamp_i) begin
            look = LOOK_LAMP;
        end else if (bright_i == 2'b00) begin
            look = LOOK_DARK;
        end else if (blink_all_i && !phase_i) begin
            look = LOOK_DARK;
        end else if (flag_i && attr_en_i) begin
            unique case (mode_i)
                MODE_CURSOR:     look = LOOK_CURSOR;
                MODE_BLINK_CHAR: look = phase_i ? LOOK_GLYPH  : LOOK_DARK;
                MODE_BLINK_CUR:  look = phase_i ? LOOK_CURSOR : LOOK_DARK;
                MODE_ALTERNATE:  look = phase_i ? LOOK_GLYPH  : LOOK_CURSOR;
                default:         look = LOOK_GLYPH;
            endcase
        end
    end

    always_comb begin
        unique case (look)
            LOOK_GLYPH: begin
                pat_d = glyph_i;
                cnt_d = glyph_slots(bright_i);
            end
            LOOK_CURSOR: begin
                pat_d = '1;
                cnt_d = cursor_slots(bright_i);
            end
            LOOK_LAMP: begin
                pat_d = '1;
                cnt_d = 3'd2;
            end
            default: begin
                pat_d = '0;
                cnt_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pat_q <= '0;
            cnt_q <= '0;
        end else if (fetch_i) begin
            pat_q <= pat_d;
            cnt_q <= cnt_d;
        end
    end

    assign lit    = drive_i && ({1'b0, sub_i} < cnt_q);
    assign cols_o = lit ? pat_q : '0;

    p_cnt_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q == 3'd0 || cnt_q == 3'd1 || cnt_q == 3'd2 || cnt_q == 3'd4);
    p_hold_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_i |=> $stable(cnt_q) && $stable(pat_q));
    p_lamp_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_i && lamp_i) |=> (cnt_q == 3'd2 && pat_q == '1));
    p_zero_bright_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_i && !lamp_i && bright_i == 2'b00) |=> cnt_q == '0);
    p_global_blink_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_i && !lamp_i && blink_all_i && !phase_i) |=> cnt_q == '0);
    p_cursor_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_i && !lamp_i && flag_i && attr_en_i && mode_i == MODE_CURSOR)
        |=> cnt_q <= 3'd2);

endmodule

// File: rtl/dot_scan_renderer.sv
module dot_scan_renderer
    import dsr_pkg::*;
#(
    parameter int CELLS  = 4,
    parameter int COLS   = 5,
    parameter int ROWS   = 7,
    parameter int CODE_W = 7,
    localparam int ROW_W  = $clog2(ROWS),
    localparam int SLOT_W = CODE_W + 1,
    localparam int ALL_C  = CELLS * COLS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CELLS*SLOT_W-1:0] chars_i,
    input  logic [1:0]              bright_i,
    input  logic                    attr_en_i,
    input  logic [1:0]              attr_mode_i,
    input  logic                    blink_all_i,
    input  logic                    lamp_test_i,
    input  logic                    blink_phase_i,
    output logic [ROW_W-1:0]        cg_row_o,
    output logic [CELLS*CODE_W-1:0] cg_code_o,
    input  logic [ALL_C-1:0]        cg_cols_i,
    output logic [ROWS-1:0]         row_sel_o,
    output logic [ALL_C-1:0]        col_en_o
);

    scan_state_t      state;
    logic [ROW_W-1:0] row;
    logic [SUB_W-1:0] sub;
    logic             fetch, drive;
    logic [ALL_C-1:0] lane_cols;

    scan_seq #(.ROWS(ROWS)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_o (state),
        .row_o   (row),
        .sub_o   (sub)
    );

    assign fetch    = (state == ST_FETCH);
    assign drive    = (state == ST_DRIVE);
    assign cg_row_o = row;

    for (genvar c = 0; c < CELLS; c++) begin : g_cell
        assign cg_code_o[c*CODE_W +: CODE_W] = chars_i[c*SLOT_W +: CODE_W];

        cell_lane #(.COLS(COLS)) u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .fetch_i     (fetch),
            .drive_i     (drive),
            .sub_i       (sub),
            .flag_i      (chars_i[c*SLOT_W + CODE_W]),
            .bright_i    (bright_i),
            .attr_en_i   (attr_en_i),
            .mode_i      (attr_mode_i),
            .blink_all_i (blink_all_i),
            .lamp_i      (lamp_test_i),
            .phase_i     (blink_phase_i),
            .glyph_i     (cg_cols_i[c*COLS +: COLS]),
            .cols_o      (lane_cols[c*COLS +: COLS])
        );
    end

    // Output process: rows and columns are driven only in drive cycles.
    always_comb begin
        row_sel_o = '0;
        col_en_o  = '0;
        unique case (state)
            ST_FETCH: begin
                row_sel_o = '0;
                col_en_o  = '0;
            end
            ST_DRIVE: begin
                for (int r = 0; r < ROWS; r++) begin
                    row_sel_o[r] = (row == ROW_W'(r));
                end
                col_en_o = lane_cols;
            end
            default: ;
        endcase
    end

    p_row_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_sel_o));
    p_dark_fetch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FETCH |-> (row_sel_o == '0 && col_en_o == '0));
    p_row_active_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DRIVE |-> $countones(row_sel_o) == 1);
    p_last_sub_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRIVE && sub != '0 && !$past(col_en_o[0]))
        |-> !col_en_o[0]);

endmodule

// File: tb/dot_scan_renderer_test.sv
module dot_scan_renderer_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] chars = '0;
    logic [1:0]  bright = 2'b11;
    logic        attr_en = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        blink_all = 1'b0;
    logic        lamp = 1'b0;
    logic        phase = 1'b1;
    logic [2:0]  cg_row;
    logic [27:0] cg_code;
    logic [19:0] cg_cols;
    logic [6:0]  row_sel;
    logic [19:0] col_en;

    int edges = 0;
    int n_checks = 0;
    int n_fail = 0;
    int wd = 0;

    int          sb_stamp[$];
    logic [6:0]  sb_sel[$];
    logic [19:0] sb_cols[$];
    string       sb_tag[$];

    logic [31:0] c_chars;
    logic [1:0]  c_bright, c_mode;
    logic        c_en, c_blink, c_lamp, c_phase;

    dot_scan_renderer uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .chars_i       (chars),
        .bright_i      (bright),
        .attr_en_i     (attr_en),
        .attr_mode_i   (mode),
        .blink_all_i   (blink_all),
        .lamp_test_i   (lamp),
        .blink_phase_i (phase),
        .cg_row_o      (cg_row),
        .cg_code_o     (cg_code),
        .cg_cols_i     (cg_cols),
        .row_sel_o     (row_sel),
        .col_en_o      (col_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [4:0] glyph(input logic [6:0] code, input logic [2:0] r);
        return code[4:0] ^ {r, r[1:0]};
    endfunction

    // Character generator model.
    always_comb begin
        for (int i = 0; i < 4; i++) begin
            cg_cols[i*5 +: 5] = glyph(cg_code[i*7 +: 7], cg_row);
        end
    end

    always @(posedge clk) begin
        if (rst_n) edges <= edges + 1;
        wd <= wd + 1;
    end

    // Expected columns of one cell in one sub-slot, from the requirements.
    function automatic logic [4:0] cell_exp(input logic [7:0] ch, input int r, input int s);
        int    n;
        logic  cur, show, dark;
        logic [4:0] g;
        int    gs;
        gs = (c_bright == 2'b00) ? 0 : (c_bright == 2'b01) ? 1 : (c_bright == 2'b10) ? 2 : 4;
        g = glyph(ch[6:0], 3'(r));
        cur = 1'b0; dark = 1'b0; show = 1'b1;
        if (c_lamp) return (s < 2) ? 5'h1f : 5'h00;
        if (c_bright == 2'b00) return 5'h00;
        if (c_blink && !c_phase) return 5'h00;
        if (ch[7] && c_en) begin
            case (c_mode)
                2'b00: cur = 1'b1;
                2'b01: dark = !c_phase;
                2'b10: begin cur = c_phase; dark = !c_phase; end
                default: cur = !c_phase;
            endcase
        end
        if (dark) show = 1'b0;
        if (!show) return 5'h00;
        if (cur) begin
            n = (gs > 2) ? 2 : gs;
            return (s < n) ? 5'h1f : 5'h00;
        end
        return (s < gs) ? g : 5'h00;
    endfunction

    task automatic push(input int stamp, input string tag);
        int p, r;
        logic [19:0] cx;
        p = (stamp - 1) % 5;
        r = ((stamp - 1) / 5) % 7;
        cx = '0;
        if (p < 4) begin
            for (int i = 0; i < 4; i++) cx[i*5 +: 5] = cell_exp(c_chars[i*8 +: 8], r, p);
            sb_sel.push_back(7'(1 << r));
        end else begin
            sb_sel.push_back(7'd0);
        end
        sb_stamp.push_back(stamp);
        sb_cols.push_back(cx);
        sb_tag.push_back(tag);
    endtask

    // Driver: waits for a fetch cycle, applies config, pushes one row slot.
    task automatic slot(input string tag, input bit disturb);
        int k;
        while (!(edges > 0 && (edges - 1) % 5 == 4)) @(negedge clk);
        chars = c_chars; bright = c_bright; attr_en = c_en; mode = c_mode;
        blink_all = c_blink; lamp = c_lamp; phase = c_phase;
        k = edges;
        for (int j = 1; j <= 5; j++) push(k + j, tag);
        repeat (2) @(negedge clk);
        if (disturb) begin
            lamp = 1'b1; bright = 2'b00; phase = ~phase; chars = ~chars;
        end
        repeat (3) @(negedge clk);
    endtask

    // Monitor.
    always @(negedge clk) begin
        if (rst_n && sb_stamp.size() > 0 && sb_stamp[0] == edges) begin
            n_checks++;
            if (row_sel !== sb_sel[0] || col_en !== sb_cols[0]) begin
                n_fail++;
                $display("FAIL %s edge %0d: row_sel=%b col_en=%h expected row_sel=%b col_en=%h",
                         sb_tag[0], edges, row_sel, col_en, sb_sel[0], sb_cols[0]);
            end
            void'(sb_stamp.pop_front()); void'(sb_sel.pop_front());
            void'(sb_cols.pop_front()); void'(sb_tag.pop_front());
        end
    end

    always @(negedge clk) begin
        if (wd > 100000) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: run hung, actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic cfg(input logic [31:0] ch, input logic [1:0] b, input logic en,
                       input logic [1:0] m, input logic bl, input logic lt, input logic ph);
        c_chars = ch; c_bright = b; c_en = en; c_mode = m;
        c_blink = bl; c_lamp = lt; c_phase = ph;
    endtask

    initial begin
        chars = 32'h53_54_4F_50;
        repeat (3) @(negedge clk);
        // R1: reset state
        n_checks++;
        if (row_sel !== 7'd0 || col_en !== 20'd0) begin
            n_fail++;
            $display("FAIL R1 reset: row_sel=%b col_en=%h expected 0 and 0", row_sel, col_en);
        end
        rst_n = 1'b1;

        // R1 R3 R2: plain glyphs at full brightness over several rows
        cfg(32'h53_54_4F_50, 2'b11, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
        slot("R1 R3 full", 1'b0);
        slot("R1 R3 full next row", 1'b0);
        cfg(32'h2A_15_7F_01, 2'b11, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
        slot("R3 other codes", 1'b0);
        // R2: brightness levels
        cfg(32'h53_54_4F_50, 2'b01, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
        slot("R2 quarter", 1'b0);
        cfg(32'h53_54_4F_50, 2'b10, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
        slot("R2 half", 1'b0);
        // R9: zero brightness darkens glyph and cursor
        cfg(32'hD3_54_4F_50, 2'b00, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1);
        slot("R9 zero bright", 1'b0);
        // R5: flag without enable, enable without flag
        cfg(32'hD3_54_CF_50, 2'b11, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
        slot("R5 flag no enable", 1'b0);
        cfg(32'h53_54_4F_50, 2'b11, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0);
        slot("R5 enable no flag", 1'b0);
        // R6 R4: attribute modes with both phases
        for (int m = 0; m < 4; m++) begin
            for (int ph = 0; ph < 2; ph++) begin
                cfg(32'h53_54_CF_50, 2'b11, 1'b1, 2'(m), 1'b0, 1'b0, 1'(ph));
                slot("R6 R4 attribute mode", 1'b0);
            end
        end
        // R4: cursor at quarter brightness, half brightness
        cfg(32'hD3_54_CF_50, 2'b01, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1);
        slot("R4 cursor quarter", 1'b0);
        cfg(32'hD3_54_CF_50, 2'b10, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0);
        slot("R4 cursor half", 1'b0);
        // R7: global blink
        cfg(32'hD3_54_4F_50, 2'b11, 1'b1, 2'b01, 1'b1, 1'b0, 1'b0);
        slot("R7 blink off phase", 1'b0);
        cfg(32'hD3_54_4F_50, 2'b11, 1'b0, 2'b01, 1'b1, 1'b0, 1'b1);
        slot("R7 blink on phase", 1'b0);
        // R8: lamp test overrides everything
        cfg(32'hD3_54_CF_50, 2'b00, 1'b1, 2'b01, 1'b1, 1'b1, 1'b0);
        slot("R8 lamp test", 1'b0);
        cfg(32'h00_00_00_00, 2'b11, 1'b0, 2'b00, 1'b0, 1'b1, 1'b1);
        slot("R8 lamp test full", 1'b0);
        // R10: mid-slot changes ignored until the next slot
        cfg(32'h53_54_4F_50, 2'b11, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
        slot("R10 mid-slot change", 1'b1);
        slot("R10 next slot", 1'b0);

        repeat (3) @(negedge clk);
        if (sb_stamp.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL R1 scoreboard: %0d items left, expected 0", sb_stamp.size());
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule